// File: doc/BRIEF.md
# Four-Phase Switched-Capacitor Boost Sequencer

This block is the digital timing core for a two-capacitor charge-pump boost stage that feeds a full-bridge DC-link. It steps through a fixed four-phase cycle. In the first three phases the two pumping capacitors are charged: first in parallel, then one capacitor stacked onto the other, then a top-up of the first. In the fourth phase the stored charge is delivered to the link at one of four gain levels. The block drives four booster switch enables and two polarity enables, one for the positive half-wave and one for the negative half-wave.

Regulation works by pulse frequency. On entry to the delivery phase, a single comparison decides whether the sampled reference magnitude is at least the sampled output magnitude. When it is not, the delivery phase is left fully idle. When it is, the reference magnitude is compared against multiples of a step size to pick the gain. That decision and the reference sign are captured once and held for the whole delivery phase. Every phase begins with a dead window in which all six enables are low. Each phase lasts `DEAD_CYC + DWELL_CYC` clocks, so one full cycle lasts four times that.

Top module: `sc_pump_sequencer`

## Requirements
- R1: In the parallel-charge phase (first phase), only en_pump[0] and en_pump[1] are high; en_pump[3:2], en_pos and en_neg are low.
- R2: In the second phase only en_pump[1] and en_pump[2] are high. In the third phase only en_pump[0] is high. Neither pattern depends on the magnitude inputs.
- R3: In the delivery phase (fourth phase), en_pump[0] and en_pump[1] are low, and en_pump[3:2] carry the gain code: 2'b11 for 4x, 2'b10 for 3x, 2'b01 for 2x and 2'b00 for 1x or no pump.
- R4: In the delivery phase with pumping enabled, en_pos is high when ref_neg=0 and en_neg is high when ref_neg=1. en_pos and en_neg are never high together, and neither is high in the first three phases.
- R5: The pump decision is ref_mag >= out_mag. When it is false, all six enables stay low for the whole delivery phase.
- R6: The gain thresholds are inclusive. ref_mag >= 3*step_mag gives 4x. Otherwise ref_mag >= 2*step_mag gives 3x. Otherwise ref_mag >= step_mag gives 2x. Anything lower gives 1x.
- R7: The pump decision, gain code and sign are captured from the inputs present at the clock edge that enters the delivery phase. Input changes after that edge have no effect until the next delivery phase.
- R8: Each phase starts with DEAD_CYC clocks (DEAD_CYC >= 1) in which all enables are low, followed by DWELL_CYC clocks of its pattern. An enabled pattern never changes directly into a different enabled pattern.
- R9: While rst is high at a clock edge, all enables are low after that edge. After rst falls, the sequence restarts from the dead window of the first phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_mag | input | MAG_W | Gain step size, in magnitude units |
| ref_mag | input | MAG_W | Sampled reference magnitude |
| out_mag | input | MAG_W | Sampled output magnitude |
| ref_neg | input | 1 | Reference half-wave sign, 1 = negative |
| en_pump | output | 4 | Booster switch enables, bit k drives switch k+1 |
| en_pos | output | 1 | Positive half-wave link enable |
| en_neg | output | 1 | Negative half-wave link enable |

## Verification
Two events can fall on the same clock edge: the capture of the delivery decision and a change in the comparator inputs. The bench forces both orderings. In one test the output magnitude flips on the falling edge just before the capture edge. In the other it flips on the falling edge just after. It then checks whether the delivery pattern follows the new or the old decision. A third case flips the inputs partway through a delivery phase and checks that the held pattern does not move.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;
  typedef enum logic [1:0] {
    PH_PARALLEL = 2'd0,
    PH_STACK    = 2'd1,
    PH_TOPUP    = 2'd2,
    PH_DELIVER  = 2'd3
  } phase_e;

  typedef struct packed {
    logic pump;
    logic hi_sel;   // drives en_pump[3]
    logic lo_sel;   // drives en_pump[2]
    logic neg;
  } deliver_t;
endpackage

// File: rtl/sc_phase_timer.sv
module sc_phase_timer
  import sc_seq_pkg::*;
#(
  parameter int DEAD_CYC  = 2,
  parameter int DWELL_CYC = 4
) (
  input  logic   clk,
  input  logic   rst,
  output phase_e phase,
  output logic   active,
  output logic   deliver_entry
);
  localparam int CMAX = (DEAD_CYC > DWELL_CYC) ? DEAD_CYC : DWELL_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DEAD_LAST  = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] DWELL_LAST = CW'(DWELL_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [1:0]    ph_q;
  logic          act_q;
  logic          seg_last;

  assign seg_last = act_q ? (cnt_q == DWELL_LAST) : (cnt_q == DEAD_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ph_q  <= 2'd0;
      act_q <= 1'b0;
    end else if (seg_last) begin
      cnt_q <= '0;
      if (act_q) begin
        act_q <= 1'b0;
        ph_q  <= ph_q + 2'd1;
      end else begin
        act_q <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase         = phase_e'(ph_q);
  assign active        = act_q;
  assign deliver_entry = act_q && seg_last && (ph_q == 2'(PH_TOPUP));
endmodule

// File: rtl/sc_gain_select.sv
module sc_gain_select
  import sc_seq_pkg::*;
#(
  parameter int MAG_W = 12
) (
  input  logic [MAG_W-1:0] step_mag,
  input  logic [MAG_W-1:0] ref_mag,
  input  logic [MAG_W-1:0] out_mag,
  input  logic             ref_neg,
  output deliver_t         decision
);
  localparam int EW = MAG_W + 2;

  logic [EW-1:0] thr_one, thr_two, thr_three, ref_ext;
  logic          pump;

  assign thr_one   = {2'b00, step_mag};
  assign thr_two   = thr_one << 1;
  assign thr_three = thr_one + thr_two;
  assign ref_ext   = {2'b00, ref_mag};
  assign pump      = (ref_mag >= out_mag);

  always_comb begin
    decision.pump   = pump;
    decision.neg    = ref_neg;
    decision.hi_sel = 1'b0;
    decision.lo_sel = 1'b0;
    if (pump) begin
      if (ref_ext >= thr_three) begin
        decision.hi_sel = 1'b1;
        decision.lo_sel = 1'b1;
      end else if (ref_ext >= thr_two) begin
        decision.hi_sel = 1'b1;
      end else if (ref_ext >= thr_one) begin
        decision.lo_sel = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_switch_drive.sv
module sc_switch_drive
  import sc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phase_e     phase,
  input  logic       active,
  input  logic       deliver_entry,
  input  deliver_t   decision,
  output logic [3:0] en_pump,
  output logic       en_pos,
  output logic       en_neg
);
  deliver_t   held_q;
  logic [3:0] pump_d;
  logic       pos_d, neg_d;

  always_ff @(posedge clk) begin
    if (rst)                held_q <= '0;
    else if (deliver_entry) held_q <= decision;
  end

  always_comb begin
    pump_d = 4'b0000;
    pos_d  = 1'b0;
    neg_d  = 1'b0;
    if (active) begin
      unique case (phase)
        PH_PARALLEL: pump_d = 4'b0011;
        PH_STACK:    pump_d = 4'b0110;
        PH_TOPUP:    pump_d = 4'b0001;
        PH_DELIVER: begin
          pump_d = {held_q.hi_sel, held_q.lo_sel, 2'b00};
          pos_d  = held_q.pump && !held_q.neg;
          neg_d  = held_q.pump &&  held_q.neg;
        end
        default: pump_d = 4'b0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_pump <= 4'b0000;
      en_pos  <= 1'b0;
      en_neg  <= 1'b0;
    end else begin
      en_pump <= pump_d;
      en_pos  <= pos_d;
      en_neg  <= neg_d;
    end
  end
endmodule

// File: rtl/sc_pump_sequencer.sv
module sc_pump_sequencer
  import sc_seq_pkg::*;
#(
  parameter int MAG_W     = 12,
  parameter int DEAD_CYC  = 2,
  parameter int DWELL_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAG_W-1:0] step_mag,
  input  logic [MAG_W-1:0] ref_mag,
  input  logic [MAG_W-1:0] out_mag,
  input  logic             ref_neg,
  output logic [3:0]       en_pump,
  output logic             en_pos,
  output logic             en_neg
);
  phase_e   phase;
  logic     active;
  logic     deliver_entry;
  deliver_t decision;

  sc_phase_timer #(
    .DEAD_CYC (DEAD_CYC),
    .DWELL_CYC(DWELL_CYC)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .phase        (phase),
    .active       (active),
    .deliver_entry(deliver_entry)
  );

  sc_gain_select #(
    .MAG_W(MAG_W)
  ) u_gain (
    .step_mag(step_mag),
    .ref_mag (ref_mag),
    .out_mag (out_mag),
    .ref_neg (ref_neg),
    .decision(decision)
  );

  sc_switch_drive u_drive (
    .clk          (clk),
    .rst          (rst),
    .phase        (phase),
    .active       (active),
    .deliver_entry(deliver_entry),
    .decision     (decision),
    .en_pump      (en_pump),
    .en_pos       (en_pos),
    .en_neg       (en_neg)
  );
endmodule

// File: rtl/sc_pump_sequencer_chk.sv
module sc_pump_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] en_pump,
  input logic       en_pos,
  input logic       en_neg
);
  logic [5:0] all_en;
  assign all_en = {en_neg, en_pos, en_pump};

  // R1: the parallel-charge pattern excludes every other switch
  p_parallel_only_r1: assert property (@(posedge clk) disable iff (rst)
    (en_pump[0] && en_pump[1]) |-> (en_pump[3:2] == 2'b00 && !en_pos && !en_neg));

  // R3: a polarity enable is high only while the charge switches are off
  p_deliver_charge_off_r3: assert property (@(posedge clk) disable iff (rst)
    (en_pos || en_neg) |-> (en_pump[1:0] == 2'b00));

  // R4: the two half-wave enables never conduct together
  p_half_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(en_pos && en_neg));

  // R5: a gain switch active in the delivery phase implies a pump decision
  p_pump_gate_r5: assert property (@(posedge clk) disable iff (rst)
    ((en_pump[3] || en_pump[2]) && !en_pump[1]) |-> (en_pos || en_neg));

  // R7: the captured decision does not move within a delivery phase
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((en_pos || en_neg) && $past(en_pos || en_neg)) |->
      ($stable(en_pump) && $stable(en_neg) && $stable(en_pos)));

  // R8: one enabled pattern never turns directly into another
  p_dead_gap_r8: assert property (@(posedge clk) disable iff (rst)
    ((|all_en) && (|$past(all_en))) |-> (all_en == $past(all_en)));

  // R9: reset clears every enable
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (all_en == 6'b000000));
endmodule

bind sc_pump_sequencer sc_pump_sequencer_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .en_pump(en_pump),
  .en_pos (en_pos),
  .en_neg (en_neg)
);

// File: tb/sc_pump_sequencer_bench.sv
module sc_pump_sequencer_bench;
  localparam int MAG_W = 12;
  localparam int DEAD  = 2;
  localparam int DWELL = 4;
  localparam int PLEN  = DEAD + DWELL;
  localparam int CYC   = 4 * PLEN;
  localparam int NVEC  = 12;

  // {step, ref, out, neg, expected {en_neg, en_pos, en_pump}} for the delivery phase
  localparam logic [42:0] VEC [NVEC] = '{
    {12'd100, 12'd350, 12'd200, 1'b0, 6'b011100},  // R3 R6 4x positive
    {12'd100, 12'd250, 12'd100, 1'b1, 6'b101000},  // R3 R6 3x negative
    {12'd100, 12'd150, 12'd150, 1'b0, 6'b010100},  // R5 equal magnitudes pump, 2x
    {12'd100, 12'd80,  12'd50,  1'b1, 6'b100000},  // R4 1x negative, link only
    {12'd100, 12'd350, 12'd351, 1'b0, 6'b000000},  // R5 output above reference
    {12'd100, 12'd300, 12'd0,   1'b0, 6'b011100},  // R6 exactly 3 steps
    {12'd100, 12'd299, 12'd0,   1'b1, 6'b101000},  // R6 just below 3 steps
    {12'd100, 12'd200, 12'd10,  1'b0, 6'b011000},  // R6 exactly 2 steps
    {12'd100, 12'd199, 12'd10,  1'b0, 6'b010100},  // R6 just below 2 steps
    {12'd100, 12'd100, 12'd10,  1'b1, 6'b100100},  // R6 exactly 1 step
    {12'd100, 12'd99,  12'd10,  1'b0, 6'b010000},  // R6 just below 1 step
    {12'd50,  12'd160, 12'd0,   1'b1, 6'b101100}   // R6 smaller step size
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [MAG_W-1:0] step_mag = '0;
  logic [MAG_W-1:0] ref_mag  = '0;
  logic [MAG_W-1:0] out_mag  = '0;
  logic             ref_neg  = 1'b0;
  logic [3:0]       en_pump;
  logic             en_pos, en_neg;

  int tcount = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tcount <= 0;
    else     tcount <= tcount + 1;
  end

  sc_pump_sequencer #(
    .MAG_W    (MAG_W),
    .DEAD_CYC (DEAD),
    .DWELL_CYC(DWELL)
  ) u_sc_pump_sequencer (
    .clk     (clk),
    .rst     (rst),
    .step_mag(step_mag),
    .ref_mag (ref_mag),
    .out_mag (out_mag),
    .ref_neg (ref_neg),
    .en_pump (en_pump),
    .en_pos  (en_pos),
    .en_neg  (en_neg)
  );

  task automatic wait_t(input int target);
    while (tcount != target) @(negedge clk);
  endtask

  task automatic apply(input int idx);
    step_mag = VEC[idx][42:31];
    ref_mag  = VEC[idx][30:19];
    out_mag  = VEC[idx][18:7];
    ref_neg  = VEC[idx][6];
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {en_neg, en_pos, en_pump};
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s at t=%0d: actual=%b expected=%b", req, tcount, act, exp);
    end
  endtask

  initial begin
    apply(0);
    repeat (3) @(negedge clk);
    check("R9 reset state", 6'b000000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      if (i > 0) begin
        wait_t(CYC * i + 2);
        apply(i);
      end else begin
        wait_t(1);  check("R8 dead window start", 6'b000000);
        wait_t(2);  check("R8 dead window end", 6'b000000);
        wait_t(3);  check("R1 parallel charge", 6'b000011);
        wait_t(6);  check("R1 parallel charge last", 6'b000011);
        wait_t(7);  check("R8 dead between phases", 6'b000000);
        wait_t(9);  check("R2 stack phase", 6'b000110);
        wait_t(15); check("R2 top-up phase", 6'b000001);
      end
      wait_t(CYC * i + 3 * PLEN + DEAD + 2);
      check("R3/R6 delivery vector", VEC[i][5:0]);
    end

    // R7: inputs flip on the falling edge after the capture edge
    begin
      int b;
      b = CYC * NVEC;
      wait_t(b + 2);
      apply(0);
      wait_t(b + 3 * PLEN);
      out_mag = 12'd400;
      wait_t(b + 3 * PLEN + DEAD + 2);
      check("R7 late change ignored", 6'b011100);

      // R7: inputs flip on the falling edge before the capture edge
      b = b + CYC;
      wait_t(b + 3 * PLEN - 1);
      out_mag = 12'd200;
      wait_t(b + 3 * PLEN + DEAD + 2);
      check("R7 early change captured", 6'b011100);

      // R2 and R5: no pump decision, charge phases still run
      b = b + CYC;
      wait_t(b + 2);
      out_mag = 12'd400;
      wait_t(b + PLEN + DEAD + 1);
      check("R2 stack independent of pump", 6'b000110);
      wait_t(b + 3 * PLEN + DEAD + 2);
      check("R5 idle delivery", 6'b000000);

      // R9: reset inside a delivery phase
      b = b + CYC;
      wait_t(b + 2);
      apply(1);
      wait_t(b + 3 * PLEN + DEAD + 2);
      check("R3 delivery before reset", 6'b101000);
      rst = 1'b1;
      @(negedge clk);
      check("R9 reset mid-delivery", 6'b000000);
      apply(2);
      @(negedge clk);
      rst = 1'b0;
      wait_t(2); check("R9 restart dead window", 6'b000000);
      wait_t(3); check("R9 restart in parallel charge", 6'b000011);
      wait_t(3 * PLEN + DEAD + 2);
      check("R9 delivery after restart", 6'b010100);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule